// File: doc/BRIEF.md
# Effective Address Generation Unit

This block forms the 32-bit data-memory address for four register-based addressing modes of a 32-bit load/store processor. On each request it takes a mode, an access size (byte, word or longword), the contents of a general register, of the index register R0, of a global base register and of the program counter, and an 8-bit displacement. It returns the address one clock later, together with a valid strobe.

Two modes add R0 to a base without scaling: the general register in one, the global base register in the other. The other two modes add a displacement that is zero-extended and then scaled by the access size. One of them adds it to the global base register. The other adds it to the program counter, which is first rounded down to a 4-byte boundary for longword accesses.

A request whose size the mode cannot use is refused: no valid strobe and an illegal flag instead. A status flag reports when the produced address is not aligned to the access size.

Top module: `ea_gen_unit`

## Requirements
- R1: Mode 2'b00 (register indexed) produces general register + R0, with no scaling and no displacement.
- R2: Mode 2'b01 (base plus displacement) produces global base + zext(disp) × 1, 2 or 4 for sizes 2'b00 byte, 2'b01 word and 2'b10 longword. The displacement is never sign-extended.
- R3: Mode 2'b10 (base indexed) produces global base + R0, unscaled.
- R4: Mode 2'b11 (PC-relative) with word size produces PC + zext(disp) × 2, using the PC unmasked.
- R5: Mode 2'b11 with longword size produces (PC AND 0xFFFFFFFC) + zext(disp) × 4.
- R6: A request with size 2'b11, or with mode 2'b11 and byte size, gives valid low and illegal high one cycle later. The address output keeps its previous value.
- R7: Every sum is taken modulo 2^32, and the carry out of bit 31 is dropped.
- R8: Inputs are sampled on the clock edge where the request strobe is high, and the result appears after that edge. A cycle without a request leaves valid, illegal and misalign low and the address unchanged.
- R9: The misalign flag is high with valid when a word address has bit 0 set or a longword address has either of bits 1:0 set. It is never high for byte accesses or without valid.
- R10: A synchronous active-high reset clears valid, illegal, misalign and the address to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_i | input | 1 | Request strobe; the other inputs are sampled while it is high |
| mode_i | input | 2 | Addressing mode select |
| size_i | input | 2 | Access size select |
| rn_i | input | 32 | General register value |
| r0_i | input | 32 | Index register R0 value |
| gbase_i | input | 32 | Global base register value |
| pc_i | input | 32 | Program counter value |
| disp_i | input | 8 | Unsigned displacement |
| ea_o | output | 32 | Effective address |
| ea_vld_o | output | 1 | Address valid strobe |
| misalign_o | output | 1 | Address not aligned to the access size |
| illegal_o | output | 1 | Request refused for an unusable mode and size pair |

## Verification
The hardest cases to reach are those where a single bit separates a correct design from a wrong one. These are a PC-relative word access from an odd PC, which must stay unmasked and so report a misaligned word, and a displacement with bit 7 set, which must not be sign-extended. The sweep covers every mode and size pairing against all 256 displacement values. It uses three register sets: one with a PC whose low bits are 2'b10, one with a PC whose low bits are 2'b11, and one whose bases sit near 0xFFFFFFFF so that the scaled sums wrap past 2^32.

// File: rtl/ea_pkg.sv
`timescale 1ns/1ps
package ea_pkg;

    localparam int XLEN   = 32;
    localparam int DISP_W = 8;

    typedef enum logic [1:0] {
        AM_IDX_REG = 2'b00,
        AM_GB_DISP = 2'b01,
        AM_GB_IDX  = 2'b10,
        AM_PC_REL  = 2'b11
    } am_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_WORD = 2'b01,
        SZ_LONG = 2'b10,
        SZ_BAD  = 2'b11
    } sz_e;

    // log2 of the access size in bytes
    function automatic logic [1:0] size_shift(input sz_e sz);
        case (sz)
            SZ_WORD: size_shift = 2'd1;
            SZ_LONG: size_shift = 2'd2;
            default: size_shift = 2'd0;
        endcase
    endfunction

    // mode/size pairing accepted by the unit
    function automatic logic pair_legal(input am_e am, input sz_e sz);
        pair_legal = (sz != SZ_BAD) && !((am == AM_PC_REL) && (sz == SZ_BYTE));
    endfunction

    // low address bits that must be zero for the access size
    function automatic logic [1:0] align_mask(input sz_e sz);
        case (sz)
            SZ_WORD: align_mask = 2'b01;
            SZ_LONG: align_mask = 2'b11;
            default: align_mask = 2'b00;
        endcase
    endfunction

endpackage

// File: rtl/ea_operand_sel.sv
`timescale 1ns/1ps
module ea_operand_sel
    import ea_pkg::*;
#(
    parameter int XLEN   = ea_pkg::XLEN,
    parameter int DISP_W = ea_pkg::DISP_W
) (
    input  am_e               am,
    input  sz_e               sz,
    input  logic [XLEN-1:0]   rn,
    input  logic [XLEN-1:0]   r0,
    input  logic [XLEN-1:0]   gbase,
    input  logic [XLEN-1:0]   pc,
    input  logic [DISP_W-1:0] disp,
    output logic [XLEN-1:0]   base,
    output logic [XLEN-1:0]   offset
);
    localparam int PAD_W = XLEN - DISP_W;

    logic [XLEN-1:0] disp_zx;
    logic [XLEN-1:0] disp_scaled;
    logic [XLEN-1:0] pc_long;

    generate
        if (PAD_W > 0) begin : g_zext
            assign disp_zx = {{PAD_W{1'b0}}, disp};
        end else begin : g_nozext
            assign disp_zx = disp[XLEN-1:0];
        end
    endgenerate

    assign disp_scaled = disp_zx << size_shift(sz);
    assign pc_long     = {pc[XLEN-1:2], 2'b00};

    always_comb begin
        base   = rn;
        offset = r0;
        case (am)
            AM_IDX_REG: begin
                base   = rn;
                offset = r0;
            end
            AM_GB_DISP: begin
                base   = gbase;
                offset = disp_scaled;
            end
            AM_GB_IDX: begin
                base   = gbase;
                offset = r0;
            end
            AM_PC_REL: begin
                base   = (sz == SZ_LONG) ? pc_long : pc;
                offset = disp_scaled;
            end
            default: begin
                base   = rn;
                offset = r0;
            end
        endcase
    end
endmodule

// File: rtl/ea_adder.sv
`timescale 1ns/1ps
module ea_adder #(
    parameter int XLEN = ea_pkg::XLEN
) (
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic [XLEN-1:0] sum
);
    logic [XLEN:0] full;
    assign full = {1'b0, a} + {1'b0, b};
    assign sum  = full[XLEN-1:0];
    logic unused_carry;
    assign unused_carry = full[XLEN];
endmodule

// File: rtl/ea_align_chk.sv
`timescale 1ns/1ps
module ea_align_chk
    import ea_pkg::*;
(
    input  logic [1:0] addr_lo,
    input  sz_e        sz,
    output logic       misaligned
);
    assign misaligned = |(addr_lo & align_mask(sz));
endmodule

// File: rtl/ea_gen_unit.sv
`timescale 1ns/1ps
module ea_gen_unit
    import ea_pkg::*;
#(
    parameter int XLEN   = ea_pkg::XLEN,
    parameter int DISP_W = ea_pkg::DISP_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_i,
    input  logic [1:0]        mode_i,
    input  logic [1:0]        size_i,
    input  logic [XLEN-1:0]   rn_i,
    input  logic [XLEN-1:0]   r0_i,
    input  logic [XLEN-1:0]   gbase_i,
    input  logic [XLEN-1:0]   pc_i,
    input  logic [DISP_W-1:0] disp_i,
    output logic [XLEN-1:0]   ea_o,
    output logic              ea_vld_o,
    output logic              misalign_o,
    output logic              illegal_o
);
    typedef struct packed {
        logic [XLEN-1:0] addr;
        logic            vld;
        logic            mis;
        logic            ill;
    } ea_resp_t;

    am_e am;
    sz_e sz;
    assign am = am_e'(mode_i);
    assign sz = sz_e'(size_i);

    logic [XLEN-1:0] base, offset, sum;
    logic            mis_c;
    logic            ok_pair;
    logic            take, refuse;
    ea_resp_t        resp_q;

    ea_operand_sel #(.XLEN(XLEN), .DISP_W(DISP_W)) u_sel (
        .am     (am),
        .sz     (sz),
        .rn     (rn_i),
        .r0     (r0_i),
        .gbase  (gbase_i),
        .pc     (pc_i),
        .disp   (disp_i),
        .base   (base),
        .offset (offset)
    );

    ea_adder #(.XLEN(XLEN)) u_add (
        .a   (base),
        .b   (offset),
        .sum (sum)
    );

    ea_align_chk u_align (
        .addr_lo    (sum[1:0]),
        .sz         (sz),
        .misaligned (mis_c)
    );

    assign ok_pair = pair_legal(am, sz);
    assign take    = req_i && ok_pair;
    assign refuse  = req_i && !ok_pair;

    always_ff @(posedge clk) begin
        if (rst) begin
            resp_q <= '0;
        end else begin
            resp_q.vld <= take;
            resp_q.ill <= refuse;
            resp_q.mis <= take && mis_c;
            if (take) begin
                resp_q.addr <= sum;
            end
        end
    end

    assign ea_o       = resp_q.addr;
    assign ea_vld_o   = resp_q.vld;
    assign misalign_o = resp_q.mis;
    assign illegal_o  = resp_q.ill;
endmodule

// File: rtl/ea_gen_unit_chk.sv
`timescale 1ns/1ps
module ea_gen_unit_chk #(
    parameter int XLEN   = 32,
    parameter int DISP_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              req_i,
    input logic [1:0]        mode_i,
    input logic [1:0]        size_i,
    input logic [XLEN-1:0]   rn_i,
    input logic [XLEN-1:0]   r0_i,
    input logic [XLEN-1:0]   gbase_i,
    input logic [XLEN-1:0]   pc_i,
    input logic [DISP_W-1:0] disp_i,
    input logic [XLEN-1:0]   ea_o,
    input logic              ea_vld_o,
    input logic              misalign_o,
    input logic              illegal_o
);
    localparam int PAD_W = XLEN - DISP_W;

    a_r1_reg_indexed: assert property (@(posedge clk) disable iff (rst)
        (req_i && mode_i == 2'b00 && size_i != 2'b11) |=> (ea_vld_o && ea_o == $past(rn_i) + $past(r0_i)));

    a_r3_base_indexed: assert property (@(posedge clk) disable iff (rst)
        (req_i && mode_i == 2'b10 && size_i != 2'b11) |=> (ea_o == $past(gbase_i) + $past(r0_i)));

    a_r4_pc_word: assert property (@(posedge clk) disable iff (rst)
        (req_i && mode_i == 2'b11 && size_i == 2'b01) |=>
        (ea_o == $past(pc_i) + ({{PAD_W{1'b0}}, $past(disp_i)} << 1)));

    a_r5_pc_long_aligned: assert property (@(posedge clk) disable iff (rst)
        (req_i && mode_i == 2'b11 && size_i == 2'b10) |=> (ea_o[1:0] == 2'b00 && !misalign_o));

    a_r6_refused: assert property (@(posedge clk) disable iff (rst)
        (req_i && (size_i == 2'b11 || (mode_i == 2'b11 && size_i == 2'b00))) |=>
        (illegal_o && !ea_vld_o && $stable(ea_o)));

    a_r8_idle: assert property (@(posedge clk) disable iff (rst)
        !req_i |=> (!ea_vld_o && !illegal_o && $stable(ea_o)));

    a_r9_flag_needs_valid: assert property (@(posedge clk) disable iff (rst)
        misalign_o |-> ea_vld_o);

    a_r6_exclusive: assert property (@(posedge clk) disable iff (rst)
        $countones({ea_vld_o, illegal_o}) <= 1);

    a_r10_reset: assert property (@(posedge clk)
        rst |=> (!ea_vld_o && !illegal_o && !misalign_o && ea_o == '0));
endmodule

bind ea_gen_unit ea_gen_unit_chk #(.XLEN(XLEN), .DISP_W(DISP_W)) u_chk (
    .clk(clk), .rst(rst), .req_i(req_i), .mode_i(mode_i), .size_i(size_i),
    .rn_i(rn_i), .r0_i(r0_i), .gbase_i(gbase_i), .pc_i(pc_i), .disp_i(disp_i),
    .ea_o(ea_o), .ea_vld_o(ea_vld_o), .misalign_o(misalign_o), .illegal_o(illegal_o)
);

// File: tb/ea_gen_unit_test.sv
`timescale 1ns/1ps
module ea_gen_unit_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_i = 1'b0;
    logic [1:0]  mode_i = 2'b00;
    logic [1:0]  size_i = 2'b00;
    logic [31:0] rn_i = '0, r0_i = '0, gbase_i = '0, pc_i = '0;
    logic [7:0]  disp_i = '0;
    logic [31:0] ea_o;
    logic        ea_vld_o, misalign_o, illegal_o;

    int checks = 0;
    int errors = 0;
    logic [31:0] last_ea = '0;

    always #4 clk = ~clk;

    ea_gen_unit uut (
        .clk(clk), .rst(rst), .req_i(req_i), .mode_i(mode_i), .size_i(size_i),
        .rn_i(rn_i), .r0_i(r0_i), .gbase_i(gbase_i), .pc_i(pc_i), .disp_i(disp_i),
        .ea_o(ea_o), .ea_vld_o(ea_vld_o), .misalign_o(misalign_o), .illegal_o(illegal_o)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", what, act, exp);
        end
    endtask

    task automatic idle_check();
        @(negedge clk);
        req_i = 1'b0;
        rn_i = 32'hDEAD_BEEF; r0_i = 32'h1234_5678;
        @(negedge clk);
        chk({31'b0, ea_vld_o},  32'd0, "R8 idle valid");
        chk({31'b0, illegal_o}, 32'd0, "R8 idle illegal");
        chk({31'b0, misalign_o},32'd0, "R8 idle misalign");
        chk(ea_o, last_ea, "R8 idle address hold");
    endtask

    task automatic one_req(input int md, input int sz, input int d, input int set);
        logic [31:0] dz, exp_ea;
        logic        bad, mis;
        string       tag;
        dz = {24'b0, d[7:0]};
        bad = (sz == 3) || (md == 3 && sz == 0);
        exp_ea = last_ea;
        tag = "R6";
        if (!bad) begin
            case (md)
                0: begin exp_ea = rn_i + r0_i; tag = "R1"; end
                1: begin exp_ea = gbase_i + (dz << sz); tag = "R2"; end
                2: begin exp_ea = gbase_i + r0_i; tag = "R3"; end
                default: begin
                    if (sz == 1) begin exp_ea = pc_i + dz * 2; tag = "R4"; end
                    else begin exp_ea = (pc_i & 32'hFFFF_FFFC) + dz * 4; tag = "R5"; end
                end
            endcase
            if (set == 2) tag = {tag, "/R7"};
        end
        mis = !bad && ((sz == 1 && exp_ea[0]) || (sz == 2 && exp_ea[1:0] != 2'b00));
        @(negedge clk);
        req_i = 1'b1; mode_i = md[1:0]; size_i = sz[1:0]; disp_i = d[7:0];
        @(negedge clk);
        req_i = 1'b0;
        chk({31'b0, ea_vld_o},  {31'b0, !bad}, $sformatf("R8 valid m%0d s%0d d%0d", md, sz, d));
        chk({31'b0, illegal_o}, {31'b0, bad},  $sformatf("R6 illegal m%0d s%0d d%0d", md, sz, d));
        chk({31'b0, misalign_o},{31'b0, mis},  $sformatf("R9 misalign m%0d s%0d d%0d", md, sz, d));
        chk(ea_o, exp_ea, $sformatf("%s address m%0d s%0d d%0d set%0d", tag, md, sz, d, set));
        last_ea = exp_ea;
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        chk(ea_o, 32'd0, "R10 reset address");
        chk({31'b0, ea_vld_o},  32'd0, "R10 reset valid");
        chk({31'b0, illegal_o}, 32'd0, "R10 reset illegal");
        chk({31'b0, misalign_o},32'd0, "R10 reset misalign");
        rst = 1'b0;
        for (int set = 0; set < 3; set++) begin
            case (set)
                0: begin rn_i = 32'h1000_0001; r0_i = 32'h0000_0003; gbase_i = 32'h2000_0002; pc_i = 32'h0000_4002; end
                1: begin rn_i = 32'h8000_0000; r0_i = 32'h0000_0004; gbase_i = 32'h0000_0100; pc_i = 32'h0000_1003; end
                default: begin rn_i = 32'hFFFF_FFF0; r0_i = 32'h0000_0021; gbase_i = 32'hFFFF_FF81; pc_i = 32'hFFFF_FFFE; end
            endcase
            for (int md = 0; md < 4; md++) begin
                for (int sz = 0; sz < 4; sz++) begin
                    for (int d = 0; d < 256; d++) begin
                        one_req(md, sz, d, set);
                    end
                end
                idle_check();
                case (set)
                    0: begin rn_i = 32'h1000_0001; r0_i = 32'h0000_0003; end
                    1: begin rn_i = 32'h8000_0000; r0_i = 32'h0000_0004; end
                    default: begin rn_i = 32'hFFFF_FFF0; r0_i = 32'h0000_0021; end
                endcase
            end
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule